// File: doc/BRIEF.md
# Statistics Counter Dump Engine

This block keeps a bank of Ethernet MAC event counters and copies them to memory when it is told to. A one-cycle pulse on an event input raises the matching counter by one. The bank holds nineteen 32-bit counters: nine for transmit outcomes, seven for receive outcomes and three for flow-control pause traffic. It also holds two 16-bit counters for management frames, one sent and one received.

A dump command carries a base address. On this command the engine captures the counters and streams them out as little-endian 32-bit words through a valid/ready write port. It then writes one completion marker word. The dump-and-clear form of the command also zeroes the counters. The number of bytes dumped is set when the command is accepted, from a device-generation input and two configuration bits. It is 64, 76 or 80 bytes. The marker always lands directly after the last data byte.

Top module: `stat_dump_engine`

## Requirements
- R1: After reset, busy_o, done_o and mem_valid_o are low and every counter is zero, so a first dump with no events returns all-zero data words.
- R2: Event bit k (0..18) raises the 32-bit counter dumped as word k, at byte offset 4k. Bits 0..8 are the transmit counters: word 0 is good transmits. Bits 9..15 are the receive counters: word 9 is good receives and word 12 is receive resource errors. Bits 16..18 are the flow-control counters. Bits 19 and 20 raise the 16-bit counters, which are packed into word 19 at bits 15:0 and bits 31:16.
- R3: The number of data words is set from gen_i, cfg_tco_i and cfg_basic_i sampled at command acceptance. gen_i=0 gives 16 words. gen_i=1 gives 16 words if cfg_basic_i is set and 19 otherwise. gen_i of 2 or 3 gives 20 words if cfg_tco_i is set; otherwise it gives 16 words if cfg_basic_i is set and 19 if not.
- R4: Each word is transferred on one cycle with mem_valid_o and mem_ready_i both high. The first word goes to the accepted base address and each later word to the previous address plus 4. Address and data hold steady while the port is stalled.
- R5: After the data words, one marker word is written at base plus 4 times the word count. It is 0x0000A005 for a plain dump and 0x0000A007 for dump-and-clear.
- R6: busy_o is high from the cycle after acceptance until the marker is accepted. done_o pulses for exactly one cycle, in the cycle after the marker handshake, with busy_o low.
- R7: Dump-and-clear returns all counters to zero. A plain dump leaves them unchanged.
- R8: No event is lost around a dump. An event in the acceptance cycle or during the dump is left out of that dump's data and shows up in the next one, counted on top of zero after a clear.
- R9: Counters saturate at their all-ones value instead of wrapping.
- R10: A command presented while busy_o is high is ignored. The dump in progress keeps its addresses, data and marker.

Port widths below use the default `ADDR_W` = 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 21 | One-cycle event pulses, one per counter |
| gen_i | input | 2 | Device generation: 0 oldest, 1 middle, 2 or 3 newest |
| cfg_tco_i | input | 1 | Include management-frame word (newest generation) |
| cfg_basic_i | input | 1 | Restrict dump to the basic counters |
| cmd_valid_i | input | 1 | Dump command strobe |
| cmd_clear_i | input | 1 | Clear counters with this dump |
| cmd_base_i | input | ADDR_W | Byte address of first dumped word |
| mem_valid_o | output | 1 | Write word valid |
| mem_ready_i | input | 1 | Write word accepted |
| mem_addr_o | output | ADDR_W | Byte address of current word |
| mem_data_o | output | 32 | Little-endian word data |
| busy_o | output | 1 | Dump in progress |
| done_o | output | 1 | One-cycle pulse after the marker is accepted |

## Verification
A command accepted at one rising edge puts word 0 on the port before the next falling edge. Each handshake edge then moves the port to the next word, and done_o rises one edge after the marker handshake. The bench drives every input at the falling edge and samples the port just after. Every word it sees is compared when mem_ready_i is high, with the expected word index advanced only on those cycles. So random stalls, events and stray commands never move the point of comparison. Expected snapshots come from a bench-side counter model. That model is frozen in the acceptance cycle before that cycle's events are added, which matches the one-edge capture.

// File: rtl/stat_dump_pkg.sv
package stat_dump_pkg;
  localparam int unsigned TX_N        = 9;
  localparam int unsigned RX_N        = 7;
  localparam int unsigned FC_N        = 3;
  localparam int unsigned MGMT_N      = 2;
  localparam int unsigned BASIC_WORDS = TX_N + RX_N;
  localparam int unsigned EXT_WORDS   = BASIC_WORDS + FC_N;
  localparam int unsigned FULL_WORDS  = EXT_WORDS + 1;
  localparam int unsigned NUM_EVT     = EXT_WORDS + MGMT_N;
  localparam int unsigned DWORD_W     = 32;
  localparam int unsigned MGMT_W      = 16;
  localparam int unsigned IDX_W       = $clog2(FULL_WORDS + 1);

  localparam logic [DWORD_W-1:0] MARK_PLAIN = 32'h0000_A005;
  localparam logic [DWORD_W-1:0] MARK_CLEAR = 32'h0000_A007;

  typedef enum logic [1:0] {
    GEN_OLD = 2'd0,
    GEN_MID = 2'd1,
    GEN_NEW = 2'd2
  } gen_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_MARK = 2'd2
  } dump_st_e;
endpackage

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
  parameter int unsigned NW   = 19,
  parameter int unsigned NN   = 2,
  parameter int unsigned WW   = 32,
  parameter int unsigned NWID = 16,
  localparam int unsigned NE  = NW + NN
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NE-1:0]            evt_i,
  input  logic                     take_i,
  input  logic                     clear_i,
  output logic [NW-1:0][WW-1:0]    snap_wide_o,
  output logic [NN-1:0][NWID-1:0]  snap_narrow_o
);
  // live counters keep running; snapshot frozen on take
  for (genvar g = 0; g < NW; g++) begin : g_wide
    logic [WW-1:0] cnt_q, snap_q, base_v, cnt_d;
    always_comb begin
      base_v = clear_i ? '0 : cnt_q;
      cnt_d  = (evt_i[g] && !(&base_v)) ? base_v + WW'(1) : base_v;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        snap_q <= '0;
      end else begin
        cnt_q <= cnt_d;
        if (take_i) snap_q <= cnt_q;
      end
    end
    assign snap_wide_o[g] = snap_q;
  end

  for (genvar h = 0; h < NN; h++) begin : g_narrow
    logic [NWID-1:0] cnt_q, snap_q, base_v, cnt_d;
    always_comb begin
      base_v = clear_i ? '0 : cnt_q;
      cnt_d  = (evt_i[NW+h] && !(&base_v)) ? base_v + NWID'(1) : base_v;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        snap_q <= '0;
      end else begin
        cnt_q <= cnt_d;
        if (take_i) snap_q <= cnt_q;
      end
    end
    assign snap_narrow_o[h] = snap_q;
  end
endmodule

// File: rtl/stat_len_sel.sv
module stat_len_sel
  import stat_dump_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  logic [1:0]    gen_i,
  input  logic          tco_en_i,
  input  logic          basic_i,
  output logic [IW-1:0] words_o
);
  logic [IW-1:0] short_len;
  assign short_len = basic_i ? IW'(BASIC_WORDS) : IW'(EXT_WORDS);

  always_comb begin
    unique case (gen_i)
      GEN_OLD: words_o = IW'(BASIC_WORDS);
      GEN_MID: words_o = short_len;
      default: words_o = tco_en_i ? IW'(FULL_WORDS) : short_len;
    endcase
  end
endmodule

// File: rtl/stat_dump_seq.sv
module stat_dump_seq
  import stat_dump_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NW     = 19,
  parameter int unsigned NN     = 2,
  parameter int unsigned WW     = 32,
  parameter int unsigned NWID   = 16,
  parameter int unsigned IW     = IDX_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic                     cmd_clear_i,
  input  logic [ADDR_W-1:0]        cmd_base_i,
  input  logic [IW-1:0]            words_i,
  input  logic [NW-1:0][WW-1:0]    snap_wide_i,
  input  logic [NN-1:0][NWID-1:0]  snap_narrow_i,
  input  logic                     mem_ready_i,
  output logic                     take_o,
  output logic                     clear_o,
  output logic                     mem_valid_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [DWORD_W-1:0]       mem_data_o,
  output logic                     busy_o,
  output logic                     done_o
);
  dump_st_e          st_q;
  logic [IW-1:0]     idx_q, last_q;
  logic [ADDR_W-1:0] addr_q;
  logic              clr_q, done_q;
  logic [DWORD_W-1:0] word;

  assign take_o  = (st_q == ST_IDLE) && cmd_valid_i;
  assign clear_o = take_o && cmd_clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      addr_q <= '0;
      clr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          st_q   <= ST_DATA;
          idx_q  <= '0;
          last_q <= words_i - IW'(1);
          addr_q <= cmd_base_i;
          clr_q  <= cmd_clear_i;
        end
        ST_DATA: if (mem_ready_i) begin
          addr_q <= addr_q + ADDR_W'(4);
          if (idx_q == last_q) st_q  <= ST_MARK;
          else                 idx_q <= idx_q + IW'(1);
        end
        ST_MARK: if (mem_ready_i) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // narrow counters share the dword after the wide ones
  always_comb begin
    word = '0;
    if (idx_q < IW'(NW)) begin
      word[WW-1:0] = snap_wide_i[idx_q];
    end else begin
      for (int j = 0; j < NN; j++) word[j*NWID +: NWID] = snap_narrow_i[j];
    end
  end

  assign mem_valid_o = (st_q != ST_IDLE);
  assign busy_o      = mem_valid_o;
  assign done_o      = done_q;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = (st_q == ST_MARK) ? (clr_q ? MARK_CLEAR : MARK_PLAIN) : word;
endmodule

// File: rtl/stat_dump_engine.sv
module stat_dump_engine
  import stat_dump_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [1:0]          gen_i,
  input  logic                cfg_tco_i,
  input  logic                cfg_basic_i,
  input  logic                cmd_valid_i,
  input  logic                cmd_clear_i,
  input  logic [ADDR_W-1:0]   cmd_base_i,
  output logic                mem_valid_o,
  input  logic                mem_ready_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DWORD_W-1:0]  mem_data_o,
  output logic                busy_o,
  output logic                done_o
);
  logic                                take, clear;
  logic [IDX_W-1:0]                    words;
  logic [EXT_WORDS-1:0][DWORD_W-1:0]   snap_wide;
  logic [MGMT_N-1:0][MGMT_W-1:0]       snap_narrow;

  stat_counter_bank #(
    .NW(EXT_WORDS), .NN(MGMT_N), .WW(DWORD_W), .NWID(MGMT_W)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt_i),
    .take_i       (take),
    .clear_i      (clear),
    .snap_wide_o  (snap_wide),
    .snap_narrow_o(snap_narrow)
  );

  stat_len_sel #(.IW(IDX_W)) u_len (
    .gen_i   (gen_i),
    .tco_en_i(cfg_tco_i),
    .basic_i (cfg_basic_i),
    .words_o (words)
  );

  stat_dump_seq #(
    .ADDR_W(ADDR_W), .NW(EXT_WORDS), .NN(MGMT_N),
    .WW(DWORD_W), .NWID(MGMT_W), .IW(IDX_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_clear_i  (cmd_clear_i),
    .cmd_base_i   (cmd_base_i),
    .words_i      (words),
    .snap_wide_i  (snap_wide),
    .snap_narrow_i(snap_narrow),
    .mem_ready_i  (mem_ready_i),
    .take_o       (take),
    .clear_o      (clear),
    .mem_valid_o  (mem_valid_o),
    .mem_addr_o   (mem_addr_o),
    .mem_data_o   (mem_data_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/stat_dump_checker.sv
module stat_dump_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [ADDR_W-1:0] cmd_base_i,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_data_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> !mem_valid_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

  assert_start_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o |=> busy_o && mem_valid_o && (mem_addr_o == $past(cmd_base_i)));

  assert_ignore_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && busy_o && !mem_ready_i |=> busy_o && $stable(mem_addr_o));

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_valid_o);

  assert_busy_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind stat_dump_engine stat_dump_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_base_i (cmd_base_i),
  .mem_valid_o(mem_valid_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/stat_dump_engine_bench.sv
module stat_dump_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] evt = '0;
  logic [1:0]  gen = '0;
  logic        cfg_tco = 1'b0, cfg_basic = 1'b0;
  logic        cmd_valid = 1'b0, cmd_clear = 1'b0;
  logic [31:0] cmd_base = '0;
  logic        mem_ready = 1'b0;
  logic        mem_valid, busy, done;
  logic [31:0] mem_addr, mem_data;

  int nchk = 0, nfail = 0, cycles = 0;
  logic [31:0] mw [0:18];
  logic [15:0] mn [0:1];

  always #5 clk = ~clk;

  stat_dump_engine u_stat_dump_engine (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .gen_i(gen),
    .cfg_tco_i(cfg_tco), .cfg_basic_i(cfg_basic),
    .cmd_valid_i(cmd_valid), .cmd_clear_i(cmd_clear), .cmd_base_i(cmd_base),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic int exp_words(input logic [1:0] g, input logic t, input logic b);
    if (g == 2'd0) return 16;
    if (g == 2'd1) return b ? 16 : 19;
    if (t) return 20;
    return b ? 16 : 19;
  endfunction

  task automatic model_evt(input logic [20:0] e);
    for (int i = 0; i < 19; i++) if (e[i] && mw[i] != 32'hFFFF_FFFF) mw[i] = mw[i] + 1;
    for (int i = 0; i < 2; i++) if (e[19+i] && mn[i] != 16'hFFFF) mn[i] = mn[i] + 1;
  endtask

  function automatic logic [20:0] rand_evt(input int pct);
    logic [20:0] e;
    for (int i = 0; i < 21; i++) e[i] = (($urandom % 100) < pct);
    return e;
  endfunction

  task automatic run_dump(input string tag, input logic clr, input logic [31:0] base,
                          input logic [1:0] g, input logic t, input logic b,
                          input int ev_pct, input int rdy_pct, input logic poke);
    logic [31:0] expw [0:20];
    int nw, k, cyc;
    @(negedge clk);
    nw = exp_words(g, t, b);
    for (int i = 0; i < 21; i++) expw[i] = '0;
    for (int i = 0; i < 19; i++) expw[i] = mw[i];
    expw[19] = {mn[1], mn[0]};
    expw[nw] = clr ? 32'h0000_A007 : 32'h0000_A005;
    cmd_valid = 1'b1; cmd_clear = clr; cmd_base = base;
    gen = g; cfg_tco = t; cfg_basic = b;
    evt = rand_evt(ev_pct);
    if (clr) begin
      for (int i = 0; i < 19; i++) mw[i] = '0;
      mn[0] = '0; mn[1] = '0;
    end
    model_evt(evt);
    @(negedge clk);
    k = 0; cyc = 0;
    while (k <= nw && cyc < 4000) begin
      evt = rand_evt(ev_pct);
      model_evt(evt);
      mem_ready = (($urandom % 100) < rdy_pct);
      cmd_valid = poke && ($urandom % 2 == 0);
      cmd_clear = $urandom % 2;
      cmd_base  = $urandom & 32'hFFFF_FFFC;
      gen = $urandom % 4; cfg_tco = $urandom % 2; cfg_basic = $urandom % 2;
      #1;
      if (!(mem_valid && busy)) begin
        check({tag, " R6 busy during dump"}, {30'd0, busy, mem_valid}, 32'd3);
        k = nw + 1;
      end else if (mem_ready) begin
        check({tag, " R4 R3 R10 address"}, mem_addr, base + 32'(4 * k));
        if (k < nw) check({tag, " R2 R8 data"}, mem_data, expw[k]);
        else        check({tag, " R5 marker"}, mem_data, expw[k]);
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0; mem_ready = 1'b0; evt = '0;
    #1;
    check({tag, " R6 done pulse/busy/valid"}, {29'd0, done, busy, mem_valid}, 32'd4);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 19; i++) mw[i] = '0;
    mn[0] = '0; mn[1] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {29'd0, busy, done, mem_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {29'd0, busy, done, mem_valid}, 32'd0);

    // R1: zeros after reset; full length
    run_dump("R1 zero", 1'b0, 32'h0000_1000, 2'd2, 1'b1, 1'b1, 0, 100, 1'b0);

    // R2: distinct count per counter
    for (int i = 0; i < 21; i++) begin
      for (int r = 0; r <= i; r++) begin
        @(negedge clk);
        evt = '0; evt[i] = 1'b1;
        model_evt(evt);
      end
    end
    @(negedge clk); evt = '0;
    run_dump("R2 map", 1'b0, 32'h0000_2000, 2'd2, 1'b1, 1'b1, 0, 100, 1'b0);

    // R3: every length selection
    run_dump("R3 old", 1'b0, 32'h0000_3000, 2'd0, 1'b1, 1'b0, 0, 60, 1'b0);
    run_dump("R3 mid basic", 1'b0, 32'h0000_3100, 2'd1, 1'b1, 1'b1, 0, 60, 1'b0);
    run_dump("R3 mid ext", 1'b0, 32'h0000_3200, 2'd1, 1'b0, 1'b0, 0, 60, 1'b0);
    run_dump("R3 new basic", 1'b0, 32'h0000_3300, 2'd2, 1'b0, 1'b1, 0, 60, 1'b0);
    run_dump("R3 new ext", 1'b0, 32'h0000_3400, 2'd2, 1'b0, 1'b0, 0, 60, 1'b0);
    run_dump("R3 gen3 full", 1'b0, 32'h0000_3500, 2'd3, 1'b1, 1'b1, 0, 60, 1'b0);

    // R7: clear then plain dumps
    run_dump("R7 clear", 1'b1, 32'h0000_4000, 2'd2, 1'b1, 1'b1, 0, 80, 1'b0);
    run_dump("R7 after clear", 1'b0, 32'h0000_4100, 2'd2, 1'b1, 1'b1, 0, 80, 1'b0);
    check("R7 counter zero", mw[0], 32'd0);

    // R8 R10: events and stray commands during dumps
    for (int n = 0; n < 40; n++) begin
      run_dump("R8 R10 random", ($urandom % 3) == 0, ($urandom & 32'h00FF_FFFC),
               $urandom % 4, $urandom % 2, $urandom % 2, 30, 20 + ($urandom % 80), 1'b1);
      repeat ($urandom % 3) begin
        @(negedge clk);
        evt = rand_evt(30); model_evt(evt);
      end
      @(negedge clk); evt = '0;
    end

    // R9: management counters saturate
    for (int n = 0; n < 65540; n++) begin
      @(negedge clk);
      evt = 21'h18_0000;
      model_evt(evt);
    end
    @(negedge clk); evt = '0;
    check("R9 model saturated", {mn[1], mn[0]}, 32'hFFFF_FFFF);
    run_dump("R9 sat", 1'b0, 32'h0000_5000, 2'd2, 1'b1, 1'b1, 0, 100, 1'b0);
    run_dump("R9 hold", 1'b1, 32'h0000_5100, 2'd2, 1'b1, 1'b1, 0, 100, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule